// File: doc/BRIEF.md
# Multi-channel prescaled down-counting timer

This peripheral holds two or three identical 32-bit timer channels behind a simple synchronous register bus. Each channel counts down from a software-loaded value once per prescaled tick. When it is at zero and another tick arrives, it takes its reload value again and sets a sticky underflow flag, which drives that channel's interrupt line when the channel's interrupt enable is set. Loading the reload register with the interval length gives a periodic event. Loading the counter and holding the reload at all ones gives a single long interval.

A single shared 8-bit run register starts and halts every channel with one write. Software reads the current count at any time. It acknowledges an event by rewriting the channel's control register with the flag bit at zero. The bus carries 32-bit words with four byte strobes. A build-time parameter moves the run register and the channel block to a more compact alternate layout.

Top module: `ptmr_bank`

## Requirements
- R1: After reset all run bits, underflow flags, interrupt enables and prescaler selects are zero, every counter and reload register reads 0xFFFFFFFF, and every `irq` bit is low.
- R2: The run register is at byte offset 4, or at offset 2 when `ALT_MAP` is 1. Bit n set makes channel n count and bit n clear halts it. Bits at or above `NUM_CH` read zero and ignore writes.
- R3: Channel n occupies byte offsets B+12n (reload), B+12n+4 (counter) and B+12n+8 (control), where B is 8, or 4 when `ALT_MAP` is 1. All three read back the stored value.
- R4: The control field at bits 2:0 selects the tick period: codes 0 to 4 give 4, 16, 64, 256 and 1024 clocks, and codes 5 to 7 give 1024. A running channel's counter drops by exactly one per tick. The first tick comes one full period after the run bit is set.
- R5: A tick that finds the counter at zero loads the reload value into the counter and sets the underflow flag (control bit 8) at the same clock edge.
- R6: The flag clears only when the control register's byte lane 1 is written with bit 8 at zero. Writing bit 8 as one leaves it as it is. An underflow at the same edge as a clearing write leaves the flag set.
- R7: `irq[n]` is high exactly while channel n's underflow flag and its interrupt enable (control bit 5) are both set.
- R8: While its run bit is clear, a channel's counter holds its value and its prescaler phase returns to zero.
- R9: Writes change only the byte lanes whose `bus_be` bit is set (lane k is data bits 8k+7:8k). Control bits other than 8, 5 and 2:0 read as zero.
- R10: Reads of offsets that are not mapped return zero. Writes to them change nothing.
- R11: A bus write to a counter takes effect at that edge even when a tick arrives at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_req | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_be | input | 4 | Byte-lane write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational while a read is requested, zero otherwise |
| irq | output | NUM_CH | Per-channel interrupt, level |

## Verification
The hardest case to reach is a clearing write to a control register that lands on the same edge as an underflow, because the tick depends on a prescaler phase the bus cannot read. The bench controls the phase: it halts the channel, which returns the phase to zero, loads a zero count, and sets the run bit. It then counts a known number of idle cycles so that the clearing write hits the exact underflow edge. The same phase control lines up a counter write with a tick. Random bursts with short counts and fast prescaler codes then create many more overlaps, and a cycle-by-cycle reference model checks each one.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

  localparam int BUS_W     = 32;
  localparam int PRE_W     = 10;
  localparam int FLAG_BIT  = 8;
  localparam int IE_BIT    = 5;

  // Terminal prescaler count for a select code (period minus one).
  function automatic logic [PRE_W-1:0] div_last(input logic [2:0] sel);
    case (sel)
      3'd0:    div_last = PRE_W'(3);
      3'd1:    div_last = PRE_W'(15);
      3'd2:    div_last = PRE_W'(63);
      3'd3:    div_last = PRE_W'(255);
      default: div_last = PRE_W'(1023);
    endcase
  endfunction

  // Replace the strobed byte lanes of a word.
  function automatic logic [BUS_W-1:0] lane_merge(input logic [BUS_W-1:0] old_v,
                                                  input logic [BUS_W-1:0] new_v,
                                                  input logic [3:0]       be);
    lane_merge = old_v;
    for (int k = 0; k < 4; k++) begin
      if (be[k]) lane_merge[8*k +: 8] = new_v[8*k +: 8];
    end
  endfunction

endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale
  import ptmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       tick
);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] last;

  always_comb begin
    last = div_last(sel);
    tick = run && (pre_q >= last);
    if (!run)      pre_d = '0;
    else if (tick) pre_d = '0;
    else           pre_d = pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // Halting returns the phase to zero.
  assert_phase_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pre_q == '0));

endmodule

// File: rtl/ptmr_channel.sv
module ptmr_channel
  import ptmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cnt_we,
  input  logic [BUS_W-1:0] cnt_wd,
  input  logic             rld_we,
  input  logic [BUS_W-1:0] rld_wd,
  input  logic             ctl_lo_we,
  input  logic [7:0]       ctl_lo_wd,
  input  logic             ctl_hi_we,
  input  logic [7:0]       ctl_hi_wd,
  output logic [BUS_W-1:0] cnt_q,
  output logic [BUS_W-1:0] rld_q,
  output logic [15:0]      ctl_rd,
  output logic             irq
);

  logic [BUS_W-1:0] cnt_d, rld_d;
  logic [2:0]       sel_q, sel_d;
  logic             ie_q, ie_d;
  logic             flag_q, flag_d;
  logic             tick, uflow, ack;
  logic             unused_ok;

  ptmr_prescale u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .sel  (sel_q),
    .tick (tick)
  );

  assign unused_ok = ^{ctl_lo_wd[7:6], ctl_lo_wd[4:3], ctl_hi_wd[7:1]};

  always_comb begin
    uflow = tick && (cnt_q == '0) && !cnt_we;
    ack   = ctl_hi_we && !ctl_hi_wd[FLAG_BIT-8];

    if (cnt_we)                cnt_d = cnt_wd;
    else if (tick && cnt_q == '0) cnt_d = rld_q;
    else if (tick)             cnt_d = cnt_q - BUS_W'(1);
    else                       cnt_d = cnt_q;

    rld_d = rld_we ? rld_wd : rld_q;
    sel_d = ctl_lo_we ? ctl_lo_wd[2:0] : sel_q;
    ie_d  = ctl_lo_we ? ctl_lo_wd[IE_BIT] : ie_q;

    if (uflow)    flag_d = 1'b1;
    else if (ack) flag_d = 1'b0;
    else          flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '1;
      rld_q  <= '1;
      sel_q  <= '0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rld_q  <= rld_d;
      sel_q  <= sel_d;
      ie_q   <= ie_d;
      flag_q <= flag_d;
    end
  end

  assign ctl_rd = {7'b0, flag_q, 2'b0, ie_q, 2'b0, sel_q};
  assign irq    = flag_q & ie_q;

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q != '0 && !cnt_we) |=> (cnt_q == $past(cnt_q) - BUS_W'(1)));

  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == '0 && !cnt_we) |=> (cnt_q == $past(rld_q) && flag_q));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(ctl_hi_we && !ctl_hi_wd[0])) |=> flag_q);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_we) |=> $stable(cnt_q));

  assert_wr_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (cnt_q == $past(cnt_wd)));

endmodule

// File: rtl/ptmr_bank.sv
module ptmr_bank
  import ptmr_pkg::*;
#(
  parameter int NUM_CH  = 3,
  parameter int ALT_MAP = 0,
  parameter int ADDR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] irq
);

  localparam int RUN_OFF = (ALT_MAP != 0) ? 2 : 4;
  localparam int RUN_W   = RUN_OFF / 4;
  localparam int RUN_L   = RUN_OFF % 4;
  localparam int CH_BASE = (ALT_MAP != 0) ? 4 : 8;
  localparam int WA      = ADDR_W - 2;

  function automatic int ch_word(input int idx);
    return (CH_BASE + 12 * idx) / 4;
  endfunction

  logic [NUM_CH-1:0] run_q, run_d;
  logic              wr, run_hit, unused_ok;
  logic [WA-1:0]     widx;
  logic [BUS_W-1:0]  cnt_a [NUM_CH];
  logic [BUS_W-1:0]  rld_a [NUM_CH];
  logic [15:0]       ctl_a [NUM_CH];

  assign wr        = bus_req && bus_we;
  assign widx      = bus_addr[ADDR_W-1:2];
  assign unused_ok = ^bus_addr[1:0];
  assign run_hit   = wr && (widx == WA'(RUN_W)) && bus_be[RUN_L];

  always_comb begin
    run_d = run_hit ? bus_wdata[8*RUN_L +: NUM_CH] : run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int BW = (CH_BASE + 12 * g) / 4;
    logic rld_hit, cnt_hit, ctl_hit;

    assign rld_hit = wr && (widx == WA'(BW));
    assign cnt_hit = wr && (widx == WA'(BW + 1));
    assign ctl_hit = wr && (widx == WA'(BW + 2));

    ptmr_channel u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_q[g]),
      .cnt_we   (cnt_hit && (bus_be != 4'b0)),
      .cnt_wd   (lane_merge(cnt_a[g], bus_wdata, bus_be)),
      .rld_we   (rld_hit && (bus_be != 4'b0)),
      .rld_wd   (lane_merge(rld_a[g], bus_wdata, bus_be)),
      .ctl_lo_we(ctl_hit && bus_be[0]),
      .ctl_lo_wd(bus_wdata[7:0]),
      .ctl_hi_we(ctl_hit && bus_be[1]),
      .ctl_hi_wd(bus_wdata[15:8]),
      .cnt_q    (cnt_a[g]),
      .rld_q    (rld_a[g]),
      .ctl_rd   (ctl_a[g]),
      .irq      (irq[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_req && !bus_we) begin
      if (widx == WA'(RUN_W)) bus_rdata[8*RUN_L +: 8] = 8'(run_q);
      for (int i = 0; i < NUM_CH; i++) begin
        if (widx == WA'(ch_word(i)))     bus_rdata = rld_a[i];
        if (widx == WA'(ch_word(i) + 1)) bus_rdata = cnt_a[i];
        if (widx == WA'(ch_word(i) + 2)) bus_rdata = {16'b0, ctl_a[i]};
      end
    end
  end

  assert_run_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_hit |=> (run_q == $past(bus_wdata[8*RUN_L +: NUM_CH])));

  assert_run_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_hit |=> $stable(run_q));

endmodule

// File: tb/sim_ptmr_bank.sv
`timescale 1ns/1ps
module sim_ptmr_bank;

  localparam int NCH = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        b_req = 1'b0, b_we = 1'b0;
  logic [5:0]  b_addr = '0;
  logic [3:0]  b_be = '0;
  logic [31:0] b_wd = '0;
  logic [31:0] rdata;
  logic [NCH-1:0] irq;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  bit irq_on = 1'b0;

  always #4 clk = ~clk;

  ptmr_bank #(.NUM_CH(NCH), .ALT_MAP(0), .ADDR_W(6)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(b_req), .bus_we(b_we),
    .bus_addr(b_addr), .bus_be(b_be), .bus_wdata(b_wd),
    .bus_rdata(rdata), .irq(irq)
  );

  // Reference state, derived from the requirements.
  logic [31:0] m_cnt [NCH];
  logic [31:0] m_rld [NCH];
  logic [2:0]  m_sel [NCH];
  logic [NCH-1:0] m_ie, m_flag, m_run;
  int          m_pre [NCH];

  function automatic int period(input logic [2:0] s);
    return (s <= 3'd4) ? (4 << (2 * s)) : 1024;
  endfunction

  function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n,
                                      input logic [3:0] be);
    logic [31:0] r = o;
    for (int k = 0; k < 4; k++) if (be[k]) r[8*k +: 8] = n[8*k +: 8];
    return r;
  endfunction

  function automatic logic [31:0] exp_read(input logic [5:0] a);
    int w = int'(a >> 2);
    logic [31:0] r = '0;
    if (w == 1) r = 32'(m_run);
    for (int c = 0; c < NCH; c++) begin
      if (w == 2 + 3*c) r = m_rld[c];
      if (w == 3 + 3*c) r = m_cnt[c];
      if (w == 4 + 3*c) r = {23'b0, m_flag[c], 2'b0, m_ie[c], 2'b0, m_sel[c]};
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    int w;
    bit wr, tk;
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_cnt[c] = '1; m_rld[c] = '1; m_sel[c] = '0; m_pre[c] = 0;
      end
      m_ie = '0; m_flag = '0; m_run = '0;
    end else begin
      wr = b_req && b_we;
      w  = int'(b_addr >> 2);
      for (int c = 0; c < NCH; c++) begin
        tk = m_run[c] && (m_pre[c] >= period(m_sel[c]) - 1);
        m_pre[c] = !m_run[c] ? 0 : (tk ? 0 : m_pre[c] + 1);
        if (wr && w == 3 + 3*c && b_be != 0) m_cnt[c] = mrg(m_cnt[c], b_wd, b_be);
        else if (tk && m_cnt[c] == 0) begin m_cnt[c] = m_rld[c]; m_flag[c] = 1'b1; tk = 1'b0; end
        else if (tk) m_cnt[c] = m_cnt[c] - 1;
        if (wr && w == 2 + 3*c) m_rld[c] = mrg(m_rld[c], b_wd, b_be);
        if (wr && w == 4 + 3*c && b_be[0]) begin m_sel[c] = b_wd[2:0]; m_ie[c] = b_wd[5]; end
        // flag clear unless an underflow was just recorded (tk cleared on wrap)
        if (wr && w == 4 + 3*c && b_be[1] && !b_wd[8] &&
            !(m_run[c] && m_cnt[c] == m_rld[c] && m_flag[c] && was_wrap(c))) m_flag[c] = 1'b0;
      end
      if (wr && w == 1 && b_be[0]) m_run = b_wd[NCH-1:0];
    end
  end

  // Wrap record for the current edge, kept by a second model process.
  bit [NCH-1:0] wrap_now;
  function automatic bit was_wrap(input int c);
    return wrap_now[c];
  endfunction
  always @(negedge clk or negedge rst_n) begin : wrap_pred
    if (!rst_n) wrap_now = '0;
    else begin
      for (int c = 0; c < NCH; c++)
        wrap_now[c] = m_run[c] && (m_pre[c] >= period(m_sel[c]) - 1) && m_cnt[c] == 0 &&
                      !(b_req && b_we && (b_addr >> 2) == 6'(3 + 3*c) && b_be != 0);
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (irq_on && rst_n) begin
      #1 check(32'(irq), 32'(m_flag & m_ie), "R7 irq");
    end
  end

  task automatic wr_reg(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    b_req = 1'b1; b_we = 1'b1; b_addr = a; b_be = be; b_wd = d;
  endtask

  task automatic idle();
    @(negedge clk);
    b_req = 1'b0; b_we = 1'b0; b_be = '0;
  endtask

  task automatic rd_model(input logic [5:0] a, input string tag);
    @(negedge clk);
    b_req = 1'b1; b_we = 1'b0; b_addr = a; b_be = '0;
    #2 check(rdata, exp_read(a), tag);
  endtask

  task automatic rd_val(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    b_req = 1'b1; b_we = 1'b0; b_addr = a; b_be = '0;
    #2 check(rdata, exp, tag);
  endtask

  task automatic dump(input string tag);
    for (int a = 0; a < 64; a += 4) rd_model(6'(a), tag);
  endtask

  initial begin : wdog
    #(8 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    irq_on = 1'b1;

    // R1 / R3 reset values at their offsets
    rd_val(6'h04, 32'h0, "R1 run");
    rd_val(6'h0C, 32'hFFFF_FFFF, "R1 cnt0");
    rd_val(6'h20, 32'hFFFF_FFFF, "R1 rld2");
    rd_val(6'h28, 32'h0, "R1 ctl2");
    dump("R3 reset map");

    // R4: ch1 by 16, 100 -> 95 after 80 clocks
    wr_reg(6'h18, 4'hF, 32'd100);
    wr_reg(6'h1C, 4'h3, 32'h1);
    wr_reg(6'h04, 4'h1, 32'h2);
    repeat (80) idle();
    rd_val(6'h18, 32'd95, "R4 count");
    repeat (7) idle();
    wr_reg(6'h04, 4'h1, 32'h0);
    repeat (40) idle();
    rd_model(6'h18, "R8 frozen");
    // R8 phase restart: 100 stays for 15 clocks then drops
    wr_reg(6'h18, 4'hF, 32'd100);
    wr_reg(6'h04, 4'h1, 32'h2);
    repeat (15) idle();
    rd_val(6'h18, 32'd100, "R8 phase");
    rd_val(6'h18, 32'd99, "R8 phase next");
    wr_reg(6'h04, 4'h1, 32'h0);

    // R5 / R7: ch0 by 4, count 2 reload 5, interrupts on
    wr_reg(6'h08, 4'hF, 32'd5);
    wr_reg(6'h0C, 4'hF, 32'd2);
    wr_reg(6'h10, 4'h3, 32'h20);
    wr_reg(6'h04, 4'h1, 32'h1);
    repeat (11) idle();
    rd_val(6'h0C, 32'd0, "R5 before wrap");
    rd_val(6'h10, 32'h120, "R5 flag");
    #1 check(32'(irq[0]), 32'd1, "R7 irq0 high");
    rd_val(6'h0C, 32'd5, "R5 reload");

    // R6 / R9 acknowledgement rules
    wr_reg(6'h10, 4'h2, 32'h100);
    rd_model(6'h10, "R6 write one keeps");
    wr_reg(6'h10, 4'h1, 32'h20);
    rd_model(6'h10, "R9 lane1 not strobed");
    wr_reg(6'h10, 4'h3, 32'h20);
    rd_model(6'h10, "R6 clear");
    wr_reg(6'h04, 4'h1, 32'h0);
    idle();

    // R6 race: ch2 underflow on the clearing edge
    wr_reg(6'h20, 4'hF, 32'd3);
    wr_reg(6'h24, 4'hF, 32'd0);
    wr_reg(6'h28, 4'h3, 32'h20);
    wr_reg(6'h04, 4'h1, 32'h4);
    repeat (3) idle();
    wr_reg(6'h28, 4'h3, 32'h20);
    rd_val(6'h28, 32'h120, "R6 underflow wins");
    rd_val(6'h24, 32'd3, "R5 race reload");
    idle();
    wr_reg(6'h24, 4'hF, 32'd50);
    rd_val(6'h24, 32'd50, "R11 write wins");
    wr_reg(6'h04, 4'h1, 32'h0);

    // R2 / R9 / R10
    wr_reg(6'h04, 4'h1, 32'hFF);
    rd_val(6'h04, 32'h7, "R2 upper bits");
    wr_reg(6'h04, 4'h1, 32'h0);
    wr_reg(6'h04, 4'hE, 32'hFFFF_FFFF);
    rd_val(6'h04, 32'h0, "R9 other lanes");
    wr_reg(6'h00, 4'hF, 32'hFFFF_FFFF);
    wr_reg(6'h30, 4'hF, 32'hFFFF_FFFF);
    wr_reg(6'h3C, 4'hF, 32'hFFFF_FFFF);
    rd_val(6'h00, 32'h0, "R10 read zero");
    rd_val(6'h34, 32'h0, "R10 read zero hi");
    wr_reg(6'h0C, 4'h4, 32'h00AB_0000);
    rd_model(6'h0C, "R9 byte lane");
    dump("R10 after unmapped");

    // Random traffic against the model
    for (int it = 0; it < 4000; it++) begin
      int op = int'($urandom % 10);
      logic [5:0] a = 6'(($urandom % 16) * 4);
      logic [31:0] d;
      if (op < 4) rd_model(a, "R3 random read");
      else if (op < 7) begin
        case (int'(a >> 2))
          1:       d = $urandom;
          2, 3, 5, 6, 8, 9: d = $urandom % 40;
          4, 7, 10: d = ($urandom & 32'h0000_0120) | (($urandom % 8 == 0) ? $urandom % 8 : $urandom % 2);
          default: d = $urandom;
        endcase
        wr_reg(a, 4'($urandom), d);
      end else idle();
    end
    idle();
    dump("R5 final state");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule